// File: doc/BRIEF.md
# Status Register and Write-Protect Controller

This block keeps the one-byte device status of a serial flash and rules on every decoded command whether it may proceed. It owns the busy flag, the write-enable latch, a three-bit block-protect code and a status-protect bit. Every command arrives as a one-cycle strobe with an operation code, a byte address and a data byte. The block answers one cycle later with an acceptance pulse. For commands that modify the array or the status byte, it also raises a start pulse that launches the self-timed cycle.

The array timer ends each self-timed cycle with a one-cycle done pulse. That pulse clears busy and drops the write-enable latch. The array is 512 KB, split into eight 64 KB sectors. The protect code locks an upper fraction of these sectors. An active-low write-protect pin, together with the status-protect bit, can freeze the status byte. After reset, a parameterised counter holds off all write-related commands for a fixed number of cycles.

Top module: `sr_wp_ctrl`

## Requirements
- R1: `status_o` bit 0 is busy, bit 1 is the write-enable latch, bits 4:2 are the protect code, bit 7 is status-protect, and bits 6:5 read 0. After reset `status_o` is 8'h00.
- R2: An accepted enable command (op 1) sets the latch. An accepted disable command (op 2) clears it. A `busy_done` pulse while busy clears both busy and the latch.
- R3: A status write (op 4), page program (op 6), sector erase (op 7) or chip erase (op 8) is refused when the latch is 0. A refused command gives `cmd_ok_o`=0 and `cyc_start_o`=0, and `status_o` does not change.
- R4: An accepted status write loads only bits 7 and 4:2 from `cmd_data`. The write is refused while status-protect is 1 and `wp_n` is 0.
- R5: Protect code 000 locks nothing, 001 locks sector 7, 010 locks sectors 6-7, 011 locks sectors 4-7, and 1xx locks all sectors. The sector number is `cmd_addr[18:16]`.
- R6: A page program or sector erase aimed at a locked sector is refused. A chip erase is refused whenever the protect code is non-zero.
- R7: While busy, only the status read (op 3) is accepted. The data read (op 5), the ID/release command (op 9), the enable command and all modify commands are refused.
- R8: For INHIBIT_CYCLES clock cycles after reset, the enable command and all modify commands are refused.
- R9: `cmd_ok_o` and `cyc_start_o` are one-cycle pulses in the cycle after the strobe. `cyc_start_o` is raised only for accepted modify commands, and busy reads 1 in that same cycle. Op codes: 0 none, 1 enable, 2 disable, 3 status read, 4 status write, 5 data read, 6 page program, 7 sector erase, 8 chip erase, 9 ID/release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Operation code (see R9) |
| cmd_addr | input | ADDR_W (19) | Target byte address |
| cmd_data | input | 8 | New status byte for a status write |
| busy_done | input | 1 | End-of-cycle pulse from the array timer |
| status_o | output | 8 | Status byte |
| cmd_ok_o | output | 1 | Command accepted, one cycle after the strobe |
| cyc_start_o | output | 1 | Start pulse for the self-timed cycle |

## Verification
A latch or busy flag holding the wrong value shows up on `status_o` one cycle after the command that disturbed it. The next modify command then gets the wrong answer on `cmd_ok_o`. A faulty region decode only surfaces when a program or erase lands near a lock boundary. For that reason, every protect code is probed at the first locked sector and at the last free address below it. A stuck inhibit counter or lock rule shows as an acceptance or start pulse that should not exist, and is caught in the cycle right after the strobe.

// File: rtl/sr_wp_pkg.sv
package sr_wp_pkg;

   typedef enum logic [3:0] {
      OP_NONE   = 4'd0,
      OP_WEN    = 4'd1,
      OP_WDIS   = 4'd2,
      OP_SRD    = 4'd3,
      OP_SWR    = 4'd4,
      OP_RD     = 4'd5,
      OP_PROG   = 4'd6,
      OP_SERASE = 4'd7,
      OP_CERASE = 4'd8,
      OP_IDREL  = 4'd9
   } sr_op_e;

   localparam int STAT_W   = 8;
   localparam int BP_W     = 3;
   localparam int BIT_BUSY = 0;
   localparam int BIT_WEL  = 1;
   localparam int BIT_BP   = 2;
   localparam int BIT_SRP  = 7;

   function automatic logic op_modifies(sr_op_e op);
      return (op == OP_SWR) || (op == OP_PROG) ||
             (op == OP_SERASE) || (op == OP_CERASE);
   endfunction

endpackage

// File: rtl/sr_inhibit_timer.sv
module sr_inhibit_timer #(
   parameter int CYCLES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   output logic inhibit_o
);
   localparam int CNT_W = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1);

   generate
      if (CYCLES < 0) begin : g_bad
         $error("sr_inhibit_timer: CYCLES must not be negative");
      end

      if (CYCLES == 0) begin : g_none
         assign inhibit_o = 1'b0;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CYCLES);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (cnt_q != LIMIT)
               cnt_q <= cnt_q + 1'b1;
         end

         assign inhibit_o = (cnt_q != LIMIT);

         // once released, the hold-off never returns without a reset
         assert_inhibit_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !inhibit_o |=> !inhibit_o)
            else $error("inhibit reasserted after release");
      end
   endgenerate

endmodule

// File: rtl/sr_region_guard.sv
module sr_region_guard #(
   parameter int NUM_SECTORS = 8,
   parameter bit USE_MASK    = 1'b1,
   localparam int SECT_W     = $clog2(NUM_SECTORS)
) (
   input  logic [2:0]        bp_i,
   input  logic [SECT_W-1:0] sector_i,
   output logic              addr_locked_o,
   output logic              any_locked_o
);
   localparam int EIGHTH = NUM_SECTORS / 8;
   localparam int QUART  = NUM_SECTORS / 4;
   localparam int HALF   = NUM_SECTORS / 2;

   logic       whole;
   logic [1:0] frac;

   assign whole        = bp_i[2];
   assign frac         = bp_i[1:0];
   assign any_locked_o = whole | (frac != 2'b00);

   generate
      if (NUM_SECTORS < 8 || (1 << SECT_W) != NUM_SECTORS) begin : g_bad
         $error("sr_region_guard: NUM_SECTORS must be a power of two, at least 8");
      end

      if (USE_MASK) begin : g_mask
         logic [NUM_SECTORS-1:0] lock_vec;
         for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sect
            localparam bit IN_EIGHTH = (s >= NUM_SECTORS - EIGHTH);
            localparam bit IN_QUART  = (s >= NUM_SECTORS - QUART);
            localparam bit IN_HALF   = (s >= NUM_SECTORS - HALF);
            assign lock_vec[s] = whole |
                                 ((frac == 2'd1) & IN_EIGHTH) |
                                 ((frac == 2'd2) & IN_QUART) |
                                 ((frac == 2'd3) & IN_HALF);
         end
         assign addr_locked_o = lock_vec[sector_i];
      end else begin : g_cmp
         logic [SECT_W:0] floor_idx;
         always_comb begin
            case (frac)
               2'd1:    floor_idx = (SECT_W+1)'(NUM_SECTORS - EIGHTH);
               2'd2:    floor_idx = (SECT_W+1)'(NUM_SECTORS - QUART);
               2'd3:    floor_idx = (SECT_W+1)'(NUM_SECTORS - HALF);
               default: floor_idx = (SECT_W+1)'(NUM_SECTORS);
            endcase
         end
         assign addr_locked_o = whole | ({1'b0, sector_i} >= floor_idx);
      end
   endgenerate

   always_comb begin
      if (whole)
         assert_whole_lock_R5: assert (addr_locked_o)
            else $error("code 1xx left a sector free");
      if (!any_locked_o)
         assert_none_free_R5: assert (!addr_locked_o)
            else $error("code 000 locked a sector");
   end

endmodule

// File: rtl/sr_status_regs.sv
module sr_status_regs
   import sr_wp_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_wel_i,
   input  logic            clr_wel_i,
   input  logic            load_i,
   input  logic [BP_W-1:0] load_bp_i,
   input  logic            load_srp_i,
   input  logic            start_i,
   input  logic            done_i,
   output logic            busy_o,
   output logic            wel_o,
   output logic [BP_W-1:0] bp_o,
   output logic            srp_o
);
   logic finish;
   assign finish = busy_o & done_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
      end else if (start_i) begin
         busy_o <= 1'b1;
      end else if (finish) begin
         busy_o <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_o <= 1'b0;
      end else if (finish) begin
         wel_o <= 1'b0;
      end else if (set_wel_i) begin
         wel_o <= 1'b1;
      end else if (clr_wel_i) begin
         wel_o <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_o  <= '0;
         srp_o <= 1'b0;
      end else if (load_i) begin
         bp_o  <= load_bp_i;
         srp_o <= load_srp_i;
      end
   end

   assert_done_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && done_i && !start_i) |=> (!busy_o && !wel_o))
      else $error("completion left busy or latch set");

endmodule

// File: rtl/sr_wp_ctrl.sv
module sr_wp_ctrl
   import sr_wp_pkg::*;
#(
   parameter int ADDR_W         = 19,
   parameter int NUM_SECTORS    = 8,
   parameter int INHIBIT_CYCLES = 5000,
   parameter bit GUARD_MASK     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [7:0]        cmd_data,
   input  logic              busy_done,
   output logic [7:0]        status_o,
   output logic              cmd_ok_o,
   output logic              cyc_start_o
);
   localparam int SECT_W = $clog2(NUM_SECTORS);

   generate
      if (ADDR_W <= SECT_W) begin : g_bad
         $error("sr_wp_ctrl: ADDR_W too small for the sector count");
      end
   endgenerate

   sr_op_e          op;
   logic            inhibit;
   logic            busy, wel, srp;
   logic [BP_W-1:0] bp;
   logic            addr_locked, any_locked;
   logic            sr_locked;
   logic            accept, start;
   logic [SECT_W-1:0] sector;
   logic            unused_in_bits;

   assign op             = sr_op_e'(cmd_op);
   assign sector         = cmd_addr[ADDR_W-1 -: SECT_W];
   assign unused_in_bits = ^{cmd_addr[ADDR_W-SECT_W-1:0], cmd_data[6:5], cmd_data[1:0]};
   assign sr_locked      = srp & ~wp_n;

   sr_inhibit_timer #(.CYCLES(INHIBIT_CYCLES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .inhibit_o (inhibit)
   );

   sr_region_guard #(.NUM_SECTORS(NUM_SECTORS), .USE_MASK(GUARD_MASK)) u_guard (
      .bp_i          (bp),
      .sector_i      (sector),
      .addr_locked_o (addr_locked),
      .any_locked_o  (any_locked)
   );

   always_comb begin
      logic may_write;
      may_write = !busy && !inhibit && wel;
      case (op)
         OP_SRD:    accept = 1'b1;
         OP_WEN:    accept = !busy && !inhibit;
         OP_WDIS,
         OP_RD,
         OP_IDREL:  accept = !busy;
         OP_SWR:    accept = may_write && !sr_locked;
         OP_PROG,
         OP_SERASE: accept = may_write && !addr_locked;
         OP_CERASE: accept = may_write && !any_locked;
         default:   accept = 1'b0;
      endcase
      accept = accept & cmd_valid;
      start  = accept & op_modifies(op);
   end

   sr_status_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_wel_i  (accept && op == OP_WEN),
      .clr_wel_i  (accept && op == OP_WDIS),
      .load_i     (accept && op == OP_SWR),
      .load_bp_i  (cmd_data[BIT_BP +: BP_W]),
      .load_srp_i (cmd_data[BIT_SRP]),
      .start_i    (start),
      .done_i     (busy_done),
      .busy_o     (busy),
      .wel_o      (wel),
      .bp_o       (bp),
      .srp_o      (srp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_ok_o    <= 1'b0;
         cyc_start_o <= 1'b0;
      end else begin
         cmd_ok_o    <= accept;
         cyc_start_o <= start;
      end
   end

   always_comb begin
      status_o                     = '0;
      status_o[BIT_BUSY]           = busy;
      status_o[BIT_WEL]            = wel;
      status_o[BIT_BP +: BP_W]     = bp;
      status_o[BIT_SRP]            = srp;
   end

   assert_busy_only_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && status_o[BIT_BUSY] && cmd_op != 4'd3) |=> !cmd_ok_o)
      else $error("command accepted while busy");

   assert_need_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !status_o[BIT_WEL]) |=> !cyc_start_o)
      else $error("modify started without the latch");

   assert_sr_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && status_o[BIT_SRP] && !wp_n) |=> $stable(status_o[7:2]))
      else $error("locked status byte changed");

   assert_inhibit_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit |-> !status_o[BIT_WEL])
      else $error("latch set during power-up hold-off");

   assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start_o |-> (status_o[BIT_BUSY] && cmd_ok_o))
      else $error("start pulse without busy");

   assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start_o |=> !cyc_start_o)
      else $error("start longer than one cycle");

endmodule

// File: tb/tb_sr_wp_ctrl.sv
module tb_sr_wp_ctrl;

   localparam int ADDR_W = 19;
   localparam int INHIB  = 40;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wp_n = 1'b1;
   logic              cmd_valid = 1'b0;
   logic [3:0]        cmd_op = 4'd0;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [7:0]        cmd_data = 8'h00;
   logic              busy_done = 1'b0;
   logic [7:0]        status_o;
   logic              cmd_ok_o;
   logic              cyc_start_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic       ok;
      logic       st;
      logic [7:0] stat;
      string      tag;
   } exp_t;

   exp_t scb[$];

   always #2.5 clk = ~clk;

   sr_wp_ctrl #(.ADDR_W(ADDR_W), .INHIBIT_CYCLES(INHIB)) dut (
      .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .busy_done(busy_done), .status_o(status_o), .cmd_ok_o(cmd_ok_o),
      .cyc_start_o(cyc_start_o)
   );

   task automatic chk(input bit good, input string tag, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!good) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic send(input logic [3:0] op, input logic [ADDR_W-1:0] a,
                       input logic [7:0] d, input logic ok, input logic st,
                       input logic [7:0] stat, input string tag);
      exp_t e;
      @(negedge clk);
      e.ok = ok; e.st = st; e.stat = stat; e.tag = tag;
      scb.push_back(e);
      cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic finish_cycle();
      @(negedge clk);
      busy_done = 1'b1;
      @(negedge clk);
      busy_done = 1'b0;
   endtask

   // monitor: compares results one cycle after each strobe
   initial begin
      forever begin
         logic v;
         exp_t e;
         @(posedge clk);
         v = cmd_valid;
         #1;
         if (v && scb.size() > 0) begin
            e = scb.pop_front();
            chk(cmd_ok_o == e.ok, e.tag, "cmd_ok", {7'd0, cmd_ok_o}, {7'd0, e.ok});
            chk(cyc_start_o == e.st, e.tag, "start", {7'd0, cyc_start_o}, {7'd0, e.st});
            chk(status_o == e.stat, e.tag, "status", status_o, e.stat);
         end else if (rst_n && (cmd_ok_o || cyc_start_o)) begin
            chk(1'b0, "R9", "stray pulse", {6'd0, cmd_ok_o, cyc_start_o}, 8'h00);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", "timeout", 8'h01, 8'h00);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(status_o == 8'h00, "R1", "reset status", status_o, 8'h00);
      chk(!cmd_ok_o && !cyc_start_o, "R1", "reset pulses", {6'd0, cmd_ok_o, cyc_start_o}, 8'h00);

      // R8 hold-off after reset
      send(4'd1, '0, 8'h00, 1'b0, 1'b0, 8'h00, "R8");
      send(4'd6, '0, 8'h00, 1'b0, 1'b0, 8'h00, "R8");
      send(4'd3, '0, 8'h00, 1'b1, 1'b0, 8'h00, "R8");
      repeat (INHIB + 10) @(negedge clk);

      // R3 latch required, R2 set/clear
      send(4'd6, 19'h00000, 8'h00, 1'b0, 1'b0, 8'h00, "R3");
      send(4'd1, '0, 8'h00, 1'b1, 1'b0, 8'h02, "R2");
      send(4'd2, '0, 8'h00, 1'b1, 1'b0, 8'h00, "R2");
      send(4'd4, '0, 8'hFF, 1'b0, 1'b0, 8'h00, "R3");
      send(4'd8, '0, 8'h00, 1'b0, 1'b0, 8'h00, "R3");

      // R4 status write of FF: only bits 7 and 4:2 land
      send(4'd1, '0, 8'h00, 1'b1, 1'b0, 8'h02, "R2");
      send(4'd4, '0, 8'hFF, 1'b1, 1'b1, 8'h9F, "R4");
      // R7 busy blocks all but status read
      send(4'd5, '0, 8'h00, 1'b0, 1'b0, 8'h9F, "R7");
      send(4'd9, '0, 8'h00, 1'b0, 1'b0, 8'h9F, "R7");
      send(4'd2, '0, 8'h00, 1'b0, 1'b0, 8'h9F, "R7");
      send(4'd3, '0, 8'h00, 1'b1, 1'b0, 8'h9F, "R7");
      finish_cycle();
      send(4'd3, '0, 8'h00, 1'b1, 1'b0, 8'h9C, "R2");

      // R4 hardware lock
      wp_n = 1'b0;
      send(4'd1, '0, 8'h00, 1'b1, 1'b0, 8'h9E, "R2");
      send(4'd4, '0, 8'h00, 1'b0, 1'b0, 8'h9E, "R4");
      wp_n = 1'b1;
      send(4'd4, '0, 8'h04, 1'b1, 1'b1, 8'h07, "R4");
      finish_cycle();
      send(4'd3, '0, 8'h00, 1'b1, 1'b0, 8'h04, "R4");

      // R5/R6 code 001: sector 7
      send(4'd1, '0, 8'h00, 1'b1, 1'b0, 8'h06, "R2");
      send(4'd6, 19'h70000, 8'h00, 1'b0, 1'b0, 8'h06, "R6");
      send(4'd7, 19'h7FFFF, 8'h00, 1'b0, 1'b0, 8'h06, "R6");
      send(4'd8, 19'h00000, 8'h00, 1'b0, 1'b0, 8'h06, "R6");
      send(4'd6, 19'h6FFFF, 8'h00, 1'b1, 1'b1, 8'h07, "R5");
      finish_cycle();
      send(4'd3, '0, 8'h00, 1'b1, 1'b0, 8'h04, "R2");

      // code 010: sectors 6-7
      send(4'd1, '0, 8'h00, 1'b1, 1'b0, 8'h06, "R2");
      send(4'd4, '0, 8'h08, 1'b1, 1'b1, 8'h0B, "R4");
      finish_cycle();
      send(4'd1, '0, 8'h00, 1'b1, 1'b0, 8'h0A, "R2");
      send(4'd6, 19'h60000, 8'h00, 1'b0, 1'b0, 8'h0A, "R5");
      send(4'd6, 19'h5FFFF, 8'h00, 1'b1, 1'b1, 8'h0B, "R5");
      finish_cycle();

      // code 011: sectors 4-7
      send(4'd1, '0, 8'h00, 1'b1, 1'b0, 8'h0A, "R2");
      send(4'd4, '0, 8'h0C, 1'b1, 1'b1, 8'h0F, "R4");
      finish_cycle();
      send(4'd1, '0, 8'h00, 1'b1, 1'b0, 8'h0E, "R2");
      send(4'd6, 19'h40000, 8'h00, 1'b0, 1'b0, 8'h0E, "R5");
      send(4'd7, 19'h3FFFF, 8'h00, 1'b1, 1'b1, 8'h0F, "R5");
      finish_cycle();

      // code 1xx: everything
      send(4'd1, '0, 8'h00, 1'b1, 1'b0, 8'h0E, "R2");
      send(4'd4, '0, 8'h10, 1'b1, 1'b1, 8'h13, "R4");
      finish_cycle();
      send(4'd1, '0, 8'h00, 1'b1, 1'b0, 8'h12, "R2");
      send(4'd6, 19'h00000, 8'h00, 1'b0, 1'b0, 8'h12, "R5");

      // code 000: chip erase allowed
      send(4'd4, '0, 8'h00, 1'b1, 1'b1, 8'h03, "R4");
      finish_cycle();
      finish_cycle();
      send(4'd3, '0, 8'h00, 1'b1, 1'b0, 8'h00, "R2");
      send(4'd1, '0, 8'h00, 1'b1, 1'b0, 8'h02, "R2");
      send(4'd8, '0, 8'h00, 1'b1, 1'b1, 8'h03, "R6");
      finish_cycle();
      send(4'd3, '0, 8'h00, 1'b1, 1'b0, 8'h00, "R9");
      send(4'd0, '0, 8'h00, 1'b0, 1'b0, 8'h00, "R9");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule